// File: doc/BRIEF.md
# Segmented Two-Level Address Translation Walker

This block converts a 32-bit program offset into a physical address. It first adds a segment base to the offset to form a linear address, and it checks the offset against a segment limit. It then either passes the linear address straight through or runs a two-level page walk. The walk reads a directory entry and then a table entry through a single memory read port.

The caller offers one request at a time on a valid/ready handshake. A request carries the offset, the segment base and limit, and a paging-enable flag. The result comes back with a one-cycle done pulse, holding either the physical address or a fault code with the faulting linear address.

The directory is found through a base register that can be reloaded to switch address spaces. A reload that arrives while a walk is running is parked and applied once the walker goes idle. Memory responses have variable latency and arrive no earlier than the cycle after the read is accepted.

Top module: `seg_page_walker`

## Requirements
- R1: The linear address is offset plus segment base, modulo 2^32. With paging off and no limit fault, done rises in the first cycle after acceptance, paddr equals the linear address, the fault code is 0 and no memory read is issued.
- R2: An offset strictly greater than the segment limit completes in the first cycle after acceptance with fault code 1 and no memory read. An offset equal to the limit is not a fault.
- R3: With paging on, the first read goes to {dir_base[31:12], linear[31:22], 2'b00}. Linear 0x0800_0000 therefore reads directory slot 32 at byte offset 0x80.
- R4: After a present directory entry, the second read goes to {entry[31:12], linear[21:12], 2'b00}.
- R5: After a present table entry, paddr is {entry[31:12], linear[11:0]} and the fault code is 0.
- R6: A directory entry whose bit 0 is clear ends the walk with fault code 2, reports the linear address on fault_addr_o, and issues no second read.
- R7: A table entry whose bit 0 is clear ends the walk with fault code 3 and reports the linear address on fault_addr_o.
- R8: Once raised, mem_req_valid_o and mem_req_addr_o stay steady until mem_req_ready_i is seen.
- R9: req_ready_o is low from acceptance until the done pulse, so at most one request is in flight. Out of reset req_ready_o is high while done_o and mem_req_valid_o are low.
- R10: A base write while idle applies to the next request. A base write during a walk leaves that walk on the old base and takes effect for the following request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request offered |
| req_ready_o | output | 1 | Walker can accept a request |
| req_offset_i | input | 32 | Program offset |
| req_seg_base_i | input | 32 | Segment base |
| req_seg_limit_i | input | 32 | Highest legal offset |
| req_paging_i | input | 1 | Run the page walk when set |
| base_wr_i | input | 1 | Load a new directory base |
| base_data_i | input | 32 | Physical address of the directory |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Entry byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read data |
| done_o | output | 1 | One-cycle completion pulse |
| fault_code_o | output | 2 | 0 none, 1 limit, 2 directory absent, 3 table absent |
| paddr_o | output | 32 | Physical address |
| fault_addr_o | output | 32 | Linear address of the last request |

## Verification
The bench uses the default split of 10 directory bits, 10 table bits and 12 page bits. With that split a 128 MiB linear address lands on directory slot 32, and the bench can predict every entry address by hand from a sparse memory model. Memory ready delay and response latency are varied between scenarios, so the held-request rule and the waiting states are exercised. A base reload is injected in the middle of a walk to show that it is deferred.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int unsigned DIR_W = 10;
  localparam int unsigned TBL_W = 10;
  localparam int unsigned PG_W  = 12;
  localparam int unsigned AW    = DIR_W + TBL_W + PG_W;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_DIR   = 2'd2,
    FLT_TBL   = 2'd3
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_TBL_REQ, ST_TBL_WAIT
  } wstate_e;
endpackage

// File: rtl/seg_check.sv
module seg_check
  import walk_pkg::*;
(
  input  logic [AW-1:0] offset_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  output logic [AW-1:0] lin_o,
  output logic          flt_o
);
  assign lin_o = offset_i + base_i;
  assign flt_o = offset_i > limit_i;
endmodule

// File: rtl/dir_base_reg.sv
module dir_base_reg
  import walk_pkg::*;
#(
  parameter logic [AW-1:0] BASE_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          wr_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] base_o,
  output logic          pend_o
);
  logic [AW-1:0] cr_q, pd_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_q   <= BASE_RST;
      pd_q   <= '0;
      pend_q <= 1'b0;
    end else if (wr_i && idle_i) begin
      cr_q   <= data_i;
      pend_q <= 1'b0;
    end else if (wr_i) begin
      pd_q   <= data_i;
      pend_q <= 1'b1;
    end else if (pend_q && idle_i) begin
      cr_q   <= pd_q;
      pend_q <= 1'b0;
    end
  end

  assign base_o = cr_q;
  assign pend_o = pend_q;

  p_base_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(cr_q));
endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
  import walk_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] lin_i,
  input  logic          seg_flt_i,
  input  logic          paging_i,
  input  logic [AW-1:0] base_i,
  output logic          idle_o,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [AW-1:0] mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [AW-1:0] mem_rsp_data_i,
  output logic          done_o,
  output logic [1:0]    fault_code_o,
  output logic [AW-1:0] paddr_o,
  output logic [AW-1:0] fault_addr_o
);
  localparam int unsigned DPAD = PG_W - DIR_W;
  localparam int unsigned TPAD = PG_W - TBL_W;

  wstate_e       st_q;
  logic [AW-1:0] lin_q, base_q, pde_q, paddr_q;
  logic          done_q;
  flt_e          flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lin_q   <= '0;
      base_q  <= '0;
      pde_q   <= '0;
      paddr_q <= '0;
      done_q  <= 1'b0;
      flt_q   <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          lin_q  <= lin_i;
          base_q <= base_i;
          if (seg_flt_i) begin
            done_q <= 1'b1;
            flt_q  <= FLT_LIMIT;
          end else if (!paging_i) begin
            done_q  <= 1'b1;
            flt_q   <= FLT_NONE;
            paddr_q <= lin_i;
          end else begin
            st_q <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ: if (mem_req_ready_i) st_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid_i) begin
          if (!mem_rsp_data_i[0]) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            flt_q  <= FLT_DIR;
          end else begin
            pde_q <= mem_rsp_data_i;
            st_q  <= ST_TBL_REQ;
          end
        end
        ST_TBL_REQ: if (mem_req_ready_i) st_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (mem_rsp_valid_i) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          if (!mem_rsp_data_i[0]) begin
            flt_q <= FLT_TBL;
          end else begin
            flt_q   <= FLT_NONE;
            paddr_q <= {mem_rsp_data_i[AW-1:PG_W], lin_q[PG_W-1:0]};
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_addr_o  = {base_q[AW-1:PG_W], lin_q[AW-1 -: DIR_W], {DPAD{1'b0}}};
    if (st_q == ST_DIR_REQ) begin
      mem_req_valid_o = 1'b1;
    end else if (st_q == ST_TBL_REQ) begin
      mem_req_valid_o = 1'b1;
      mem_req_addr_o  = {pde_q[AW-1:PG_W], lin_q[PG_W+TBL_W-1:PG_W], {TPAD{1'b0}}};
    end
  end

  assign idle_o       = st_q == ST_IDLE;
  assign done_o       = done_q;
  assign fault_code_o = flt_q;
  assign paddr_o      = paddr_q;
  assign fault_addr_o = lin_q;

  p_bypass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !seg_flt_i && !paging_i |=> done_o && !mem_req_valid_o && fault_code_o == FLT_NONE);
  p_limit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && seg_flt_i |=> done_o && !mem_req_valid_o && fault_code_o == FLT_LIMIT);
  p_pde_absent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DIR_WAIT && mem_rsp_valid_i && !mem_rsp_data_i[0] |=> done_o && fault_code_o == FLT_DIR);
  p_mem_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
endmodule

// File: rtl/seg_page_walker.sv
module seg_page_walker
  import walk_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_offset_i,
  input  logic [31:0]   req_seg_base_i,
  input  logic [31:0]   req_seg_limit_i,
  input  logic          req_paging_i,
  input  logic          base_wr_i,
  input  logic [31:0]   base_data_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [31:0]   mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [31:0]   mem_rsp_data_i,
  output logic          done_o,
  output logic [1:0]    fault_code_o,
  output logic [31:0]   paddr_o,
  output logic [31:0]   fault_addr_o
);
  logic [AW-1:0] lin, dir_base;
  logic          seg_flt, idle, pend, start;

  seg_check u_seg (
    .offset_i(req_offset_i), .base_i(req_seg_base_i), .limit_i(req_seg_limit_i),
    .lin_o(lin), .flt_o(seg_flt)
  );

  dir_base_reg u_base (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle), .wr_i(base_wr_i),
    .data_i(base_data_i), .base_o(dir_base), .pend_o(pend)
  );

  // a parked base write must land before the next request is taken
  assign req_ready_o = idle && !pend;
  assign start       = req_valid_i && req_ready_o;

  walk_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .lin_i(lin),
    .seg_flt_i(seg_flt), .paging_i(req_paging_i), .base_i(dir_base),
    .idle_o(idle), .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .done_o(done_o), .fault_code_o(fault_code_o),
    .paddr_o(paddr_o), .fault_addr_o(fault_addr_o)
  );

  p_one_walk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |-> !req_ready_o);
endmodule

// File: tb/seg_page_walker_bench.sv
module seg_page_walker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready, req_paging = 0;
  logic [31:0] req_offset = 0, req_seg_base = 0, req_seg_limit = 0;
  logic        base_wr = 0;
  logic [31:0] base_data = 0;
  logic        mem_req_valid, mem_ready, rsp_valid;
  logic [31:0] mem_req_addr, rsp_data;
  logic        done;
  logic [1:0]  fcode;
  logic [31:0] paddr, faddr;

  int checks = 0, errors = 0;
  int gap = 0, lat = 0;
  int fetch_n = 0;
  logic [31:0] fetch_log [0:7];
  logic [31:0] mem [logic [31:0]];

  int          r_cyc, r_fetch;
  logic [31:0] r_paddr, r_faddr;
  logic [1:0]  r_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_page_walker u_seg_page_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_offset_i(req_offset), .req_seg_base_i(req_seg_base), .req_seg_limit_i(req_seg_limit),
    .req_paging_i(req_paging), .base_wr_i(base_wr), .base_data_i(base_data),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_ready), .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data), .done_o(done),
    .fault_code_o(fcode), .paddr_o(paddr), .fault_addr_o(faddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    logic [31:0] a;
    mem_ready = 0; rsp_valid = 0; rsp_data = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (mem_req_valid) begin
        a = mem_req_addr;
        for (int i = 0; i < gap; i++) begin
          @(negedge clk);
          chk(mem_req_valid && mem_req_addr === a, "R8 request held", mem_req_addr, a);
        end
        mem_ready = 1;
        @(negedge clk);
        mem_ready = 0;
        fetch_log[fetch_n % 8] = a;
        fetch_n++;
        for (int i = 0; i < lat; i++) @(negedge clk);
        rsp_valid = 1;
        rsp_data = mem.exists(a) ? mem[a] : 32'h0;
      end
    end
  end

  task automatic do_req(input logic [31:0] off, input logic [31:0] sb, input logic [31:0] lim, input logic pg);
    int f0, n;
    n = 0;
    @(negedge clk);
    while (!req_ready && n < 2000) begin @(negedge clk); n++; end
    req_offset = off; req_seg_base = sb; req_seg_limit = lim; req_paging = pg;
    req_valid = 1;
    f0 = fetch_n;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready || done, "R9 ready dropped while busy", {31'b0, req_ready}, 32'h0);
    r_cyc = 0;
    while (!done && r_cyc < 2000) begin @(negedge clk); r_cyc++; end
    r_paddr = paddr; r_faddr = faddr; r_code = fcode; r_fetch = fetch_n - f0;
    @(negedge clk);
    chk(!done || req_ready, "R9 done is one cycle", {31'b0, done}, 32'h0);
  endtask

  task automatic write_base(input logic [31:0] v);
    base_wr = 1; base_data = v;
    @(negedge clk);
    base_wr = 0;
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R9 reset ready", {31'b0, req_ready}, 32'h1);
    chk(done === 1'b0, "R9 reset done", {31'b0, done}, 32'h0);
    chk(mem_req_valid === 1'b0, "R9 reset mem idle", {31'b0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_bypass;
    do_req(32'h1234_5678, 32'h0010_0000, 32'hFFFF_FFFF, 1'b0);
    chk(r_cyc == 0, "R1 done next cycle", r_cyc, 0);
    chk(r_paddr == 32'h1244_5678, "R1 paddr", r_paddr, 32'h1244_5678);
    chk(r_code == 2'd0 && r_fetch == 0, "R1 no fault no read", {r_code, 30'(r_fetch)}, 0);
    do_req(32'hFFFF_F000, 32'h0000_2000, 32'hFFFF_FFFF, 1'b0);
    chk(r_paddr == 32'h0000_1000, "R1 wraps", r_paddr, 32'h0000_1000);
  endtask

  task automatic t_limit;
    do_req(32'h0000_2000, 32'h0, 32'h0000_1FFF, 1'b1);
    chk(r_cyc == 0 && r_code == 2'd1, "R2 limit fault", r_code, 1);
    chk(r_fetch == 0, "R2 no reads", r_fetch, 0);
    do_req(32'h0000_1FFF, 32'h0, 32'h0000_1FFF, 1'b0);
    chk(r_code == 2'd0 && r_paddr == 32'h1FFF, "R2 at limit ok", r_code, 0);
  endtask

  task automatic t_walk;
    gap = 2; lat = 3;
    do_req(32'h0800_0ABC, 32'h0, 32'hFFFF_FFFF, 1'b1);
    chk(fetch_log[(fetch_n-2)%8] == 32'h0000_3080, "R3 slot 32", fetch_log[(fetch_n-2)%8], 32'h3080);
    chk(fetch_log[(fetch_n-1)%8] == 32'h0004_5000, "R4 table addr", fetch_log[(fetch_n-1)%8], 32'h45000);
    chk(r_code == 2'd0 && r_paddr == 32'h0ABC_DABC, "R5 paddr", r_paddr, 32'h0ABC_DABC);
    gap = 0; lat = 0;
    do_req(32'h0040_1000, 32'h0800_0000, 32'hFFFF_FFFF, 1'b1);
    chk(fetch_log[(fetch_n-2)%8] == 32'h0000_3084, "R3 seg base added", fetch_log[(fetch_n-2)%8], 32'h3084);
    chk(fetch_log[(fetch_n-1)%8] == 32'h0005_6004, "R4 table index", fetch_log[(fetch_n-1)%8], 32'h56004);
    chk(r_paddr == 32'h0777_7000, "R5 paddr 2", r_paddr, 32'h0777_7000);
  endtask

  task automatic t_absent;
    gap = 1; lat = 1;
    do_req(32'h0C00_0123, 32'h0, 32'hFFFF_FFFF, 1'b1);
    chk(r_code == 2'd2, "R6 dir absent code", r_code, 2);
    chk(r_faddr == 32'h0C00_0123 && r_fetch == 1, "R6 addr and one read", r_faddr, 32'h0C00_0123);
    do_req(32'h0800_5FFF, 32'h0, 32'hFFFF_FFFF, 1'b1);
    chk(r_code == 2'd3 && r_fetch == 2, "R7 table absent code", r_code, 3);
    chk(r_faddr == 32'h0800_5FFF, "R7 fault addr", r_faddr, 32'h0800_5FFF);
  endtask

  task automatic t_base;
    gap = 1; lat = 2;
    write_base(32'h0000_7000);
    do_req(32'h0800_0010, 32'h0, 32'hFFFF_FFFF, 1'b1);
    chk(fetch_log[(fetch_n-2)%8] == 32'h0000_7080, "R10 idle write", fetch_log[(fetch_n-2)%8], 32'h7080);
    chk(r_paddr == 32'h0111_1010, "R10 new space paddr", r_paddr, 32'h0111_1010);
    fork
      do_req(32'h0800_0010, 32'h0, 32'hFFFF_FFFF, 1'b1);
      begin repeat (4) @(negedge clk); write_base(32'h0000_3000); end
    join
    chk(fetch_log[(fetch_n-2)%8] == 32'h0000_7080, "R10 busy write deferred", fetch_log[(fetch_n-2)%8], 32'h7080);
    do_req(32'h0800_0010, 32'h0, 32'hFFFF_FFFF, 1'b1);
    chk(fetch_log[(fetch_n-2)%8] == 32'h0000_3080, "R10 deferred write applied", fetch_log[(fetch_n-2)%8], 32'h3080);
    chk(r_paddr == 32'h0ABC_D010, "R10 old space paddr", r_paddr, 32'h0ABC_D010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem[32'h0000_3080] = 32'h0004_5001;
    mem[32'h0004_5000] = 32'h0ABC_D001;
    mem[32'h0000_3084] = 32'h0005_6003;
    mem[32'h0005_6004] = 32'h0777_7001;
    mem[32'h0000_7080] = 32'h0009_9001;
    mem[32'h0009_9000] = 32'h0111_1001;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    write_base(32'h0000_3000);
    t_bypass;
    t_limit;
    t_walk;
    t_absent;
    t_base;
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule